// File: doc/BRIEF.md
# Halt-Mode Power Controller

This block sits beside a small CPU core and decides what happens when the core asks to halt. A single halt request strobe resolves into one of two power-saving modes, selected by the oscillator-interrupt-enable configuration bit. In the timekeeping halt mode the oscillator and the real-time counter keep running, and the CPU and peripheral clocks are gated. In the full halt mode every clock the block drives is gated.

Each mode has its own wake rules. A timekeeping halt ends at once on the real-time-counter interrupt or on one of a parameterised subset of wake lines, and the CPU resumes with no settling time. A full halt ends on a smaller parameterised subset of wake lines and always passes through a settling window. The same window is used after any reset request. Its length is set by a parameter and counted on the always-on oscillator clock. When the CPU clock comes back, a one-cycle wake pulse tells the core whether to service the waking interrupt or to fetch its reset vector.

On entry to the timekeeping halt the block also strobes a load of the interrupt-mask bits to the enabling value. While the block is in that mode it keeps the watchdog from issuing a reset. All control and status pins are plain level or strobe signals, with no handshake.

Top module: `halt_power_ctrl`

## Requirements
- R1: After `rst_ni` is released, all four clock enables are 1, `wake_vld_o` and `imask_ld_o` are 0, `wake_cause_o` is 0 (none) and `wdg_hold_o` is 0.
- R2: In the run state, a `halt_req_i` with `osc_irq_en_i`=1 and no wake source active enters the timekeeping halt on the next edge. The outputs are then oscillator and real-time-counter enables 1, CPU and peripheral enables 0. `imask_ld_o` pulses for one cycle with `imask_o`=2'b10.
- R3: In the run state, a `halt_req_i` with `osc_irq_en_i`=0 enters the full halt on the next edge, and all four clock enables become 0.
- R4: In the timekeeping halt, `rtc_irq_i` or a wake line whose bit is set in `AH_WAKE_MASK` (default bits 0 and 1) returns the block to run on the next edge with all enables 1. Wake lines outside the mask are ignored.
- R5: If a timekeeping-halt wake source is already active when the halt is requested, the CPU clock never drops. In the next cycle both `imask_ld_o` and `wake_vld_o` pulse, with cause interrupt.
- R6: In the full halt, `rtc_irq_i` and wake lines outside `FH_WAKE_MASK` (default bit 0) are ignored. A wake line in the mask starts a settling window that lasts exactly `DELAY_CYCLES` cycles, with only the oscillator enable at 1. Run follows the window.
- R7: `ext_rst_i` in any state starts the settling window on the next edge. The window then ends with wake cause reset (2'b10). A new `ext_rst_i` during the window restarts the full count.
- R8: `ext_rst_i` takes priority over any interrupt in the same cycle.
- R9: `wdg_hold_o` is 1 exactly while the block is in the timekeeping halt and `wdg_active_i` is 1.
- R10: `wake_vld_o` is a one-cycle pulse in the first cycle the CPU clock is enabled after a wake, or in the immediate-wake cycle. `wake_cause_o` is 2'b01 for interrupt and 2'b10 for reset, and it holds until the next wake.
- R11: `halt_req_i` is ignored outside the run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| halt_req_i | input | 1 | Halt request strobe from the CPU |
| osc_irq_en_i | input | 1 | Oscillator interrupt enable; selects the halt mode |
| rtc_irq_i | input | 1 | Real-time-counter interrupt |
| wake_irq_i | input | N_WAKE | Wake-capable interrupt lines |
| ext_rst_i | input | 1 | Reset request that exits any state |
| wdg_active_i | input | 1 | Watchdog running |
| osc_en_o | output | 1 | Oscillator enable |
| rtc_en_o | output | 1 | Real-time-counter clock enable |
| cpu_en_o | output | 1 | CPU clock enable |
| periph_en_o | output | 1 | Peripheral clock enable |
| imask_o | output | 2 | Value to load into the interrupt-mask bits |
| imask_ld_o | output | 1 | Strobe to load `imask_o` |
| wake_vld_o | output | 1 | Wake pulse |
| wake_cause_o | output | 2 | 01 interrupt, 10 reset vector fetch |
| wdg_hold_o | output | 1 | Suppresses watchdog reset |

## Verification
The bench targets a reset request that arrives in the same cycle as an interrupt. A design that let the interrupt win would resume the CPU at once and report an interrupt cause. It also checks the settling window down to the exact cycle: an off-by-one counter would show up as the CPU enable rising one cycle early or late, both after reset and when a reset lands partway through a window. Unmasked wake lines and the real-time-counter interrupt during the full halt must leave all clocks off. The bench also exercises the case where a wake source is already pending at the halt request, where a faulty design would drop the CPU clock instead of waking at once.

// File: rtl/halt_pkg.sv
package halt_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_AHALT  = 2'd1,
    ST_FHALT  = 2'd2,
    ST_SETTLE = 2'd3
  } pm_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_IRQ  = 2'd1,
    CAUSE_RST  = 2'd2
  } wake_cause_e;

  typedef struct packed {
    logic osc;
    logic rtc;
    logic cpu;
    logic periph;
  } clk_en_t;

  localparam logic [1:0] IMASK_AHALT = 2'b10;

endpackage

// File: rtl/halt_wake_sense.sv
module halt_wake_sense #(
  parameter int unsigned N_WAKE = 4,
  parameter logic [N_WAKE-1:0] AH_MASK = 4'b0011,
  parameter logic [N_WAKE-1:0] FH_MASK = 4'b0001
) (
  input  logic              rtc_irq_i,
  input  logic [N_WAKE-1:0] wake_irq_i,
  input  logic              ext_rst_i,
  output logic              ah_wake_o,
  output logic              fh_wake_o,
  output logic              rst_evt_o
);

  // timekeeping halt: counter interrupt plus the wider line subset
  assign ah_wake_o = rtc_irq_i | (|(wake_irq_i & AH_MASK));
  // full halt: counter is unclocked, so only the narrow line subset counts
  assign fh_wake_o = |(wake_irq_i & FH_MASK);
  assign rst_evt_o = ext_rst_i;

endmodule

// File: rtl/halt_settle_cnt.sv
module halt_settle_cnt #(
  parameter int unsigned DELAY_CYCLES = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic done_o
);

  localparam int unsigned CNT_W = (DELAY_CYCLES > 2) ? $clog2(DELAY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (run_i && !done_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = (cnt_q == LAST);

endmodule

// File: rtl/halt_mode_fsm.sv
module halt_mode_fsm
  import halt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        halt_req_i,
  input  logic        osc_irq_en_i,
  input  logic        ah_wake_i,
  input  logic        fh_wake_i,
  input  logic        rst_evt_i,
  input  logic        settle_done_i,
  output pm_state_e   state_o,
  output logic        cnt_clr_o,
  output logic        wake_vld_o,
  output wake_cause_e wake_cause_o,
  output logic        imask_ld_o
);

  pm_state_e   st_q, st_d;
  wake_cause_e pend_q, pend_d;
  wake_cause_e cause_q, cause_d;
  logic        vld_q, vld_d;
  logic        ld_q, ld_d;

  always_comb begin
    st_d      = st_q;
    pend_d    = pend_q;
    cause_d   = cause_q;
    vld_d     = 1'b0;
    ld_d      = 1'b0;
    cnt_clr_o = 1'b0;
    if (rst_evt_i) begin
      // reset request outranks every interrupt, in every state
      st_d      = ST_SETTLE;
      pend_d    = CAUSE_RST;
      cnt_clr_o = 1'b1;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (halt_req_i) begin
            cnt_clr_o = 1'b1;
            if (osc_irq_en_i) begin
              ld_d = 1'b1;
              if (ah_wake_i) begin
                vld_d   = 1'b1;
                cause_d = CAUSE_IRQ;
              end else begin
                st_d = ST_AHALT;
              end
            end else begin
              st_d = ST_FHALT;
            end
          end
        end
        ST_AHALT: begin
          if (ah_wake_i) begin
            st_d    = ST_RUN;
            vld_d   = 1'b1;
            cause_d = CAUSE_IRQ;
          end
        end
        ST_FHALT: begin
          if (fh_wake_i) begin
            st_d      = ST_SETTLE;
            pend_d    = CAUSE_IRQ;
            cnt_clr_o = 1'b1;
          end
        end
        ST_SETTLE: begin
          if (settle_done_i) begin
            st_d    = ST_RUN;
            vld_d   = 1'b1;
            cause_d = pend_q;
          end
        end
        default: st_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_RUN;
      pend_q  <= CAUSE_NONE;
      cause_q <= CAUSE_NONE;
      vld_q   <= 1'b0;
      ld_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      pend_q  <= pend_d;
      cause_q <= cause_d;
      vld_q   <= vld_d;
      ld_q    <= ld_d;
    end
  end

  assign state_o      = st_q;
  assign wake_vld_o   = vld_q;
  assign wake_cause_o = cause_q;
  assign imask_ld_o   = ld_q;

endmodule

// File: rtl/halt_clk_decode.sv
module halt_clk_decode
  import halt_pkg::*;
(
  input  pm_state_e state_i,
  input  logic      wdg_active_i,
  output clk_en_t   en_o,
  output logic      wdg_hold_o
);

  always_comb begin
    unique case (state_i)
      ST_RUN:    en_o = '{osc: 1'b1, rtc: 1'b1, cpu: 1'b1, periph: 1'b1};
      ST_AHALT:  en_o = '{osc: 1'b1, rtc: 1'b1, cpu: 1'b0, periph: 1'b0};
      ST_FHALT:  en_o = '{osc: 1'b0, rtc: 1'b0, cpu: 1'b0, periph: 1'b0};
      ST_SETTLE: en_o = '{osc: 1'b1, rtc: 1'b0, cpu: 1'b0, periph: 1'b0};
      default:   en_o = '{osc: 1'b1, rtc: 1'b1, cpu: 1'b1, periph: 1'b1};
    endcase
  end

  assign wdg_hold_o = (state_i == ST_AHALT) && wdg_active_i;

endmodule

// File: rtl/halt_power_ctrl.sv
module halt_power_ctrl
  import halt_pkg::*;
#(
  parameter int unsigned N_WAKE       = 4,
  parameter logic [N_WAKE-1:0] AH_WAKE_MASK = 4'b0011,
  parameter logic [N_WAKE-1:0] FH_WAKE_MASK = 4'b0001,
  parameter int unsigned DELAY_CYCLES = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_req_i,
  input  logic              osc_irq_en_i,
  input  logic              rtc_irq_i,
  input  logic [N_WAKE-1:0] wake_irq_i,
  input  logic              ext_rst_i,
  input  logic              wdg_active_i,
  output logic              osc_en_o,
  output logic              rtc_en_o,
  output logic              cpu_en_o,
  output logic              periph_en_o,
  output logic [1:0]        imask_o,
  output logic              imask_ld_o,
  output logic              wake_vld_o,
  output logic [1:0]        wake_cause_o,
  output logic              wdg_hold_o
);

  logic        ah_wake, fh_wake, rst_evt;
  logic        cnt_clr, settle_done;
  pm_state_e   state;
  wake_cause_e cause;
  clk_en_t     en;

  halt_wake_sense #(
    .N_WAKE (N_WAKE),
    .AH_MASK(AH_WAKE_MASK),
    .FH_MASK(FH_WAKE_MASK)
  ) u_sense (
    .rtc_irq_i (rtc_irq_i),
    .wake_irq_i(wake_irq_i),
    .ext_rst_i (ext_rst_i),
    .ah_wake_o (ah_wake),
    .fh_wake_o (fh_wake),
    .rst_evt_o (rst_evt)
  );

  halt_mode_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .halt_req_i   (halt_req_i),
    .osc_irq_en_i (osc_irq_en_i),
    .ah_wake_i    (ah_wake),
    .fh_wake_i    (fh_wake),
    .rst_evt_i    (rst_evt),
    .settle_done_i(settle_done),
    .state_o      (state),
    .cnt_clr_o    (cnt_clr),
    .wake_vld_o   (wake_vld_o),
    .wake_cause_o (cause),
    .imask_ld_o   (imask_ld_o)
  );

  halt_settle_cnt #(
    .DELAY_CYCLES(DELAY_CYCLES)
  ) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .run_i (state == ST_SETTLE),
    .done_o(settle_done)
  );

  halt_clk_decode u_dec (
    .state_i     (state),
    .wdg_active_i(wdg_active_i),
    .en_o        (en),
    .wdg_hold_o  (wdg_hold_o)
  );

  assign osc_en_o     = en.osc;
  assign rtc_en_o     = en.rtc;
  assign cpu_en_o     = en.cpu;
  assign periph_en_o  = en.periph;
  assign imask_o      = IMASK_AHALT;
  assign wake_cause_o = cause;

endmodule

// File: rtl/halt_power_ctrl_chk.sv
module halt_power_ctrl_chk #(
  parameter int unsigned DELAY_CYCLES = 4096
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ext_rst_i,
  input logic       wdg_active_i,
  input logic       osc_en_o,
  input logic       rtc_en_o,
  input logic       cpu_en_o,
  input logic       periph_en_o,
  input logic       wake_vld_o,
  input logic [1:0] wake_cause_o,
  input logic       wdg_hold_o
);

  logic in_settle;
  int unsigned settle_cnt;

  assign in_settle = osc_en_o && !rtc_en_o && !cpu_en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      settle_cnt <= 0;
    end else if (ext_rst_i || !in_settle) begin
      settle_cnt <= 0;
    end else begin
      settle_cnt <= settle_cnt + 1;
    end
  end

  // R3
  osc_off_all_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> (!rtc_en_o && !cpu_en_o && !periph_en_o));

  // R2
  ahalt_periph_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rtc_en_o && !cpu_en_o) |-> (osc_en_o && !periph_en_o));

  // R10
  wake_at_resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_en_o) |-> wake_vld_o);

  // R10
  wake_cpu_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_vld_o |-> cpu_en_o);

  // R8
  rst_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rst_i |=> (in_settle && !wake_vld_o));

  // R9
  wdg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdg_hold_o |-> (rtc_en_o && !cpu_en_o && wdg_active_i));

  // R6
  settle_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_settle |-> (settle_cnt < DELAY_CYCLES));

  // R6
  settle_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_settle && !ext_rst_i && settle_cnt == DELAY_CYCLES - 1) |=> (cpu_en_o && wake_vld_o));

  // R7
  rst_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_vld_o && wake_cause_o == 2'b10) |-> $past(in_settle));

endmodule

bind halt_power_ctrl halt_power_ctrl_chk #(
  .DELAY_CYCLES(DELAY_CYCLES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ext_rst_i   (ext_rst_i),
  .wdg_active_i(wdg_active_i),
  .osc_en_o    (osc_en_o),
  .rtc_en_o    (rtc_en_o),
  .cpu_en_o    (cpu_en_o),
  .periph_en_o (periph_en_o),
  .wake_vld_o  (wake_vld_o),
  .wake_cause_o(wake_cause_o),
  .wdg_hold_o  (wdg_hold_o)
);

// File: tb/halt_power_ctrl_tb.sv
`timescale 1ns/1ps
module halt_power_ctrl_tb;

  localparam int D = 4096;
  localparam logic [3:0] AHM = 4'b0011;
  localparam logic [3:0] FHM = 4'b0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 0, cfg = 0, rtc = 0, xrst = 0, wdg = 0;
  logic [3:0] wake = '0;
  logic osc_en, rtc_en, cpu_en, per_en, ld, vld, hold;
  logic [1:0] imask, cause;

  int n_chk = 0;
  int n_err = 0;
  bit armed = 0;

  // bench model
  int m_st = 0, m_cnt = 0, m_cause = 0, m_pend = 0;
  bit m_vld = 0, m_ld = 0;

  always #2.5 clk = ~clk;

  halt_power_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .halt_req_i(halt_req), .osc_irq_en_i(cfg),
    .rtc_irq_i(rtc), .wake_irq_i(wake), .ext_rst_i(xrst), .wdg_active_i(wdg),
    .osc_en_o(osc_en), .rtc_en_o(rtc_en), .cpu_en_o(cpu_en), .periph_en_o(per_en),
    .imask_o(imask), .imask_ld_o(ld), .wake_vld_o(vld), .wake_cause_o(cause),
    .wdg_hold_o(hold)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_cause = 0; m_pend = 0; m_vld = 0; m_ld = 0;
    end else begin
      m_vld = 0; m_ld = 0;
      if (xrst) begin
        m_st = 3; m_cnt = 0; m_pend = 2;
      end else begin
        case (m_st)
          0: if (halt_req) begin
               if (cfg) begin
                 m_ld = 1;
                 if (rtc || (wake & AHM) != 0) begin m_vld = 1; m_cause = 1; end
                 else m_st = 1;
               end else m_st = 2;
             end
          1: if (rtc || (wake & AHM) != 0) begin m_st = 0; m_vld = 1; m_cause = 1; end
          2: if ((wake & FHM) != 0) begin m_st = 3; m_cnt = 0; m_pend = 1; end
          default: if (m_cnt == D - 1) begin m_st = 0; m_vld = 1; m_cause = m_pend; end
                   else m_cnt++;
        endcase
      end
    end
  end

  function automatic string st_tag(int s);
    case (s)
      0: return "R4";
      1: return "R2";
      2: return "R3";
      default: return "R6";
    endcase
  endfunction

  always @(negedge clk) begin
    if (armed && rst_n) begin
      chk({st_tag(m_st), " osc"}, osc_en, (m_st != 2));
      chk({st_tag(m_st), " rtc"}, rtc_en, (m_st <= 1));
      chk({st_tag(m_st), " cpu"}, cpu_en, (m_st == 0));
      chk({st_tag(m_st), " periph"}, per_en, (m_st == 0));
      chk("R10 wake_vld", vld, m_vld);
      chk("R7 wake_cause", cause, m_cause);
      chk("R5 imask_ld", ld, m_ld);
      if (ld) chk("R2 imask value", imask, 2);
      chk("R9 wdg_hold", hold, (m_st == 1) && wdg);
    end
  end

  task automatic apply(bit h, bit c, bit r, logic [3:0] w, bit x, bit wd);
    @(negedge clk);
    #1;
    halt_req = h; cfg = c; rtc = r; wake = w; xrst = x; wdg = wd;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) apply(0, cfg, 0, 4'b0, 0, wdg);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1b5e));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 osc", osc_en, 1); chk("R1 rtc", rtc_en, 1);
    chk("R1 cpu", cpu_en, 1); chk("R1 periph", per_en, 1);
    chk("R1 vld", vld, 0); chk("R1 cause", cause, 0);
    chk("R1 ld", ld, 0); chk("R1 hold", hold, 0);
    armed = 1;

    // R2 enter timekeeping halt, R4 unmasked line ignored then counter irq wakes
    apply(1, 1, 0, 4'b0, 0, 1); idle(3);
    apply(0, 1, 0, 4'b0100, 0, 1); idle(2);
    apply(0, 1, 1, 4'b0, 0, 0); idle(3);
    // R4 masked line bit 1 wakes
    apply(1, 1, 0, 4'b0, 0, 0); idle(2);
    apply(0, 1, 0, 4'b0010, 0, 0); idle(3);
    // R5 wake source pending at request
    apply(1, 1, 1, 4'b0, 0, 0);
    @(negedge clk);
    chk("R5 cpu stays on", cpu_en, 1);
    chk("R5 wake pulse", vld, 1);
    idle(3);

    // R3 full halt; R6 counter irq and line 1 ignored, line 0 wakes via window
    apply(1, 0, 0, 4'b0, 0, 0); idle(2);
    apply(0, 0, 1, 4'b1110, 0, 0);
    @(negedge clk);
    chk("R6 ignored in full halt", osc_en, 0);
    idle(2);
    apply(0, 0, 0, 4'b0001, 0, 0); idle(D + 4);

    // R11 halt request ignored in timekeeping halt
    apply(1, 1, 0, 4'b0, 0, 1); idle(2);
    apply(1, 0, 0, 4'b0, 0, 1);
    @(negedge clk);
    chk("R11 still halted", rtc_en, 1);
    // R8 reset and irq same cycle
    apply(0, 1, 1, 4'b0011, 1, 1);
    @(negedge clk);
    chk("R8 reset wins cpu", cpu_en, 0);
    chk("R8 reset wins vld", vld, 0);
    // R7 reset mid-window restarts count
    idle(100);
    apply(0, 1, 0, 4'b0, 1, 0); idle(D + 4);
    @(negedge clk);
    chk("R7 cause reset", cause, 2);

    // R7 reset in run, and from full halt
    apply(0, 1, 0, 4'b0, 1, 0); idle(D + 3);
    apply(1, 0, 0, 4'b0, 0, 0); idle(2);
    apply(0, 0, 0, 4'b0001, 1, 0); idle(D + 3);

    // constrained random
    for (int i = 0; i < 20000; i++) begin
      bit h, c, r, x, wd;
      logic [3:0] w;
      h  = ($urandom_range(7) == 0);
      c  = ($urandom_range(3) != 0);
      r  = ($urandom_range(19) == 0);
      x  = ($urandom_range(1999) == 0);
      wd = $urandom_range(1);
      w  = '0;
      for (int b = 0; b < 4; b++) w[b] = ($urandom_range(24) == 0);
      apply(h, c, r, w, x, wd);
    end
    idle(4);

    armed = 0;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule